// File: doc/BRIEF.md
# Sampling Tap Sweep Controller

This block runs the characterisation sweep that precedes sampling-point selection on a high-speed card bus. When started, it steps a receive sampling-clock tap through every position twice. For each probe it presents a tap number, raises a request to an external probe engine, and waits for an acknowledge. The acknowledge carries two results: a flag saying whether the tuning command completed without error, and the word produced by the sampled-data comparison.

Each probe writes one bit into each of two result vectors. Both vectors are indexed by probe number, not by tap number. A window selector downstream consumes the vectors once the block signals done. Probes are separated by a fixed settle interval, counted in clock cycles. Some requests end at once with a status code and no probing: a bus mode that needs no tuning, a tap count of zero, or a tap count too large for the vectors.

Top module: `tap_sweep_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `probe_req` are low, `status` is 0, and both result vectors are zero.
- R2: A start request with `bus_mode` 2'b00 or 2'b01 (modes that need no tuning) finishes at once. `done` is high in the cycle after the start edge, `status` is 2'b01, and no probe is issued.
- R3: A start request with `bus_mode` 2'b10 or 2'b11 and `tap_count` equal to zero finishes at once with `status` 2'b10 and no probe.
- R4: A start request in a tuning mode where twice `tap_count` is equal to or larger than `VEC_W` finishes at once with `status` 2'b11 and no probe.
- R5: Any other start request issues exactly 2·N probes, where N is the tap count. Probe i presents `tap_sel` = i mod N.
- R6: Bit i of `pass_vec` holds `probe_cmd_ok` as sampled on the acknowledge of probe i. Bits at 2·N and above read zero. Every accepted start clears the vector.
- R7: Bit i of `cmp_vec` is 1 exactly when `probe_cmp_word` is all zeros on the acknowledge of probe i. Bits at 2·N and above read zero. Every accepted start clears the vector.
- R8: `probe_req` and `tap_sel` stay steady until `probe_ack` is seen. An acknowledge that arrives while no request is pending has no effect.
- R9: Between an acknowledge and the next request, `probe_req` is low for exactly `SETTLE_CYC` cycles.
- R10: A start request that arrives while a sweep is running is ignored. Tap count, mode and results all come from the request that began the sweep.
- R11: A sweep ends with `done` high for one cycle, in the cycle after the last acknowledge, with `status` 2'b00. `status` holds its value until the next finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a sweep; taken only when idle |
| tap_count | input | TAP_W | Number of tap positions N |
| bus_mode | input | 2 | Bus speed mode; 2'b1x needs tuning |
| probe_req | output | 1 | Probe request to the probe engine |
| tap_sel | output | TAP_W | Tap position for the current probe |
| probe_ack | input | 1 | Probe finished; result inputs are valid |
| probe_cmd_ok | input | 1 | Tuning command completed without error |
| probe_cmp_word | input | CMP_W | Sampled-data comparison result; zero means a match |
| busy | output | 1 | A request is being processed |
| done | output | 1 | One-cycle finish pulse |
| status | output | 2 | 00 swept, 01 no tuning needed, 10 no taps, 11 too many taps |
| pass_vec | output | VEC_W | Command pass flags, indexed by probe number |
| cmp_vec | output | VEC_W | Data-match flags, indexed by probe number |

## Verification
The bound checker watches several things on every cycle. A request is held until it is acknowledged. The tap number stays below the latched tap count. Requests appear only while busy. The settle gap is exact, and done is a single-cycle pulse. The three immediate-finish codes follow one cycle after the start edge, and a start during a sweep does not end it. Other properties need whole scenarios, which only the bench's scripted responder can show. These are the exact probe-by-probe tap order, the bit contents of both vectors, the clearing of stale results by a later rejected request, and the fact that stray acknowledges and a mid-sweep start leave the results untouched.

// File: rtl/tsw_pkg.sv
// Package: shared status codes, sequencer phases and mode decode for the
// tap sweep controller. Assumes a 2-bit bus mode code.
package tsw_pkg;

    typedef enum logic [1:0] {
        SW_OK    = 2'b00,
        SW_SKIP  = 2'b01,
        SW_NOTAP = 2'b10,
        SW_RANGE = 2'b11
    } sweep_status_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PROBE,
        PH_SETTLE,
        PH_DONE
    } sweep_phase_e;

    localparam logic [1:0] MODE_FAST_A = 2'b10;
    localparam logic [1:0] MODE_FAST_B = 2'b11;

    // True when the bus mode needs a sampling sweep.
    function automatic logic mode_needs_sweep(input logic [1:0] m);
        return (m == MODE_FAST_A) || (m == MODE_FAST_B);
    endfunction

endpackage

// File: rtl/tsw_settle_timer.sv
// Settle timer: after a load it counts down so that expired is low for
// CYC-1 cycles and then high. Assumes CYC >= 1.
module tsw_settle_timer #(
    parameter int CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);

    logic [CW-1:0] cnt;

    // Load with CYC-1 on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(CYC - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/tsw_result_vec.sv
// Result vector: one flag per probe index. Cleared as a whole, written one
// bit at a time. Assumes idx < W whenever wr is high.
module tsw_result_vec #(
    parameter int W  = 32,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [IW-1:0] idx,
    input  logic          bit_in,
    output logic [W-1:0]  vec
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic flag;

        // Per-bit flag: clear has priority, then an indexed write.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                flag <= 1'b0;
            end else if (wr && (idx == IW'(g))) begin
                flag <= bit_in;
            end
        end

        assign vec[g] = flag;
    end
endmodule

// File: rtl/tsw_sequencer.sv
// Sequencer: accepts a start request, screens mode and tap count, then
// steps 2*N probes with a tap counter that wraps at N. Assumes TAP_W <= 30.
module tsw_sequencer
    import tsw_pkg::*;
#(
    parameter int VEC_W = 32,
    parameter int TAP_W = 8,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TAP_W-1:0] tap_count,
    input  logic [1:0]       bus_mode,
    input  logic             probe_ack,
    input  logic             settle_done,
    output logic             probe_req,
    output logic [TAP_W-1:0] tap_sel,
    output logic [IDX_W-1:0] probe_idx,
    output logic             clr_results,
    output logic             rec_result,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status
);
    sweep_phase_e  phase;
    sweep_status_e status_q;
    logic [TAP_W-1:0] n_q;
    logic [IDX_W-1:0] last_idx;
    logic [31:0]      two_n;
    logic             take;

    assign two_n = 32'(tap_count) << 1;
    assign take  = (phase == PH_IDLE) && start;

    // Phase, probe index, tap position and status bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            probe_idx <= '0;
            tap_sel   <= '0;
            n_q       <= '0;
            last_idx  <= '0;
            status_q  <= SW_OK;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        probe_idx <= '0;
                        tap_sel   <= '0;
                        n_q       <= tap_count;
                        last_idx  <= IDX_W'(two_n - 32'd1);
                        if (!mode_needs_sweep(bus_mode)) begin
                            status_q <= SW_SKIP;
                            phase    <= PH_DONE;
                        end else if (tap_count == '0) begin
                            status_q <= SW_NOTAP;
                            phase    <= PH_DONE;
                        end else if (two_n >= 32'(VEC_W)) begin
                            status_q <= SW_RANGE;
                            phase    <= PH_DONE;
                        end else begin
                            phase <= PH_PROBE;
                        end
                    end
                end
                PH_PROBE: begin
                    if (probe_ack) begin
                        if (probe_idx == last_idx) begin
                            status_q <= SW_OK;
                            phase    <= PH_DONE;
                        end else begin
                            phase <= PH_SETTLE;
                        end
                    end
                end
                PH_SETTLE: begin
                    if (settle_done) begin
                        probe_idx <= probe_idx + 1'b1;
                        tap_sel   <= (tap_sel == n_q - 1'b1) ? '0 : tap_sel + 1'b1;
                        phase     <= PH_PROBE;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    // Decoded strobes and outputs from the current phase.
    always_comb begin
        probe_req   = (phase == PH_PROBE);
        rec_result  = (phase == PH_PROBE) && probe_ack;
        clr_results = take;
        busy        = (phase != PH_IDLE);
        done        = (phase == PH_DONE);
        status      = status_q;
    end
endmodule

// File: rtl/tap_sweep_ctrl.sv
// Top: sampling tap sweep controller. Ties the sequencer to the settle timer
// and the two probe-indexed result vectors. Assumes SETTLE_CYC >= 1 and
// VEC_W >= 2.
module tap_sweep_ctrl #(
    parameter int VEC_W      = 32,
    parameter int TAP_W      = 8,
    parameter int CMP_W      = 32,
    parameter int SETTLE_CYC = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TAP_W-1:0] tap_count,
    input  logic [1:0]       bus_mode,
    output logic             probe_req,
    output logic [TAP_W-1:0] tap_sel,
    input  logic             probe_ack,
    input  logic             probe_cmd_ok,
    input  logic [CMP_W-1:0] probe_cmp_word,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status,
    output logic [VEC_W-1:0] pass_vec,
    output logic [VEC_W-1:0] cmp_vec
);
    localparam int IDX_W = $clog2(VEC_W);

    logic [IDX_W-1:0] probe_idx;
    logic             clr_results;
    logic             rec_result;
    logic             settle_done;
    logic             cmp_match;

    assign cmp_match = (probe_cmp_word == '0);

    tsw_sequencer #(
        .VEC_W(VEC_W), .TAP_W(TAP_W), .IDX_W(IDX_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .tap_count(tap_count),
        .bus_mode(bus_mode), .probe_ack(probe_ack), .settle_done(settle_done),
        .probe_req(probe_req), .tap_sel(tap_sel), .probe_idx(probe_idx),
        .clr_results(clr_results), .rec_result(rec_result), .busy(busy),
        .done(done), .status(status)
    );

    tsw_settle_timer #(
        .CYC(SETTLE_CYC)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .load(rec_result), .expired(settle_done)
    );

    tsw_result_vec #(
        .W(VEC_W), .IW(IDX_W)
    ) u_pass (
        .clk(clk), .rst_n(rst_n), .clr(clr_results), .wr(rec_result),
        .idx(probe_idx), .bit_in(probe_cmd_ok), .vec(pass_vec)
    );

    tsw_result_vec #(
        .W(VEC_W), .IW(IDX_W)
    ) u_cmp (
        .clk(clk), .rst_n(rst_n), .clr(clr_results), .wr(rec_result),
        .idx(probe_idx), .bit_in(cmp_match), .vec(cmp_vec)
    );
endmodule

// File: rtl/tsw_checker.sv
// Checker: temporal properties of the tap sweep controller, attached by bind.
// Assumes the same parameters as the checked instance.
module tsw_checker #(
    parameter int VEC_W      = 32,
    parameter int TAP_W      = 8,
    parameter int SETTLE_CYC = 50000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [TAP_W-1:0] tap_count,
    input logic [1:0]       bus_mode,
    input logic             probe_req,
    input logic [TAP_W-1:0] tap_sel,
    input logic             probe_ack,
    input logic             busy,
    input logic             done,
    input logic [1:0]       status
);
    logic [TAP_W-1:0] n_seen;
    logic [31:0]      gap;
    logic             ack_seen;

    // Latch the tap count of each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) n_seen <= '0;
        else if (start && !busy) n_seen <= tap_count;
    end

    // Count request-low cycles since the last acknowledge within a sweep.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            gap      <= '0;
            ack_seen <= 1'b0;
        end else if (probe_req && probe_ack) begin
            gap      <= '0;
            ack_seen <= 1'b1;
        end else if (!probe_req && gap != 32'hFFFF_FFFF) begin
            gap <= gap + 1;
        end
    end

    assert_req_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        probe_req |-> busy);

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req && !probe_ack) |=> (probe_req && $stable(tap_sel)));

    assert_tap_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        probe_req |-> (tap_sel < n_seen));

    assert_settle_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(probe_req) && ack_seen) |-> (gap == 32'(SETTLE_CYC)));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_skip_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !bus_mode[1]) |=> (done && status == 2'b01));

    assert_no_taps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && bus_mode[1] && tap_count == '0) |=> (done && status == 2'b10));

    assert_too_many_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && bus_mode[1] && tap_count != '0 &&
         (32'(tap_count) << 1) >= 32'(VEC_W)) |=> (done && status == 2'b11));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !done && !(probe_req && probe_ack)) |=> busy);
endmodule

bind tap_sweep_ctrl tsw_checker #(
    .VEC_W(VEC_W), .TAP_W(TAP_W), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .tap_count(tap_count),
    .bus_mode(bus_mode), .probe_req(probe_req), .tap_sel(tap_sel),
    .probe_ack(probe_ack), .busy(busy), .done(done), .status(status)
);

// File: tb/sim_tap_sweep_ctrl.sv
// Bench: scripted probe responder plus a scoreboard of expected taps and
// expected finish results.
module sim_tap_sweep_ctrl;
    localparam int VW = 16;
    localparam int TW = 8;
    localparam int CW = 8;
    localparam int SC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [TW-1:0] tap_count = '0;
    logic [1:0] bus_mode = 2'b00;
    logic probe_ack = 1'b0;
    logic probe_cmd_ok = 1'b0;
    logic [CW-1:0] probe_cmp_word = '1;
    logic probe_req, busy, done;
    logic [TW-1:0] tap_sel;
    logic [1:0] status;
    logic [VW-1:0] pass_vec, cmp_vec;

    tap_sweep_ctrl #(.VEC_W(VW), .TAP_W(TW), .CMP_W(CW), .SETTLE_CYC(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .tap_count(tap_count),
        .bus_mode(bus_mode), .probe_req(probe_req), .tap_sel(tap_sel),
        .probe_ack(probe_ack), .probe_cmd_ok(probe_cmd_ok),
        .probe_cmp_word(probe_cmp_word), .busy(busy), .done(done),
        .status(status), .pass_vec(pass_vec), .cmp_vec(cmp_vec)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [1:0]    st;
        logic [VW-1:0] pv;
        logic [VW-1:0] cv;
        int            probes;
    } res_t;

    int total = 0;
    int bad = 0;
    int exp_tap_q[$];
    res_t exp_res_q[$];
    logic [VW-1:0] pass_pat, cmp_pat;
    int ack_delay = 0;
    bit spurious = 0;
    int probes_seen = 0;
    int gap_cnt = 0;
    bit gap_arm = 0;
    bit done_prev = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string st_tag(input logic [1:0] s);
        case (s)
            2'b00:   return "R11";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    // Responder: answers each request from the script and checks tap and gap.
    initial begin : responder
        forever begin
            @(negedge clk);
            if (probe_req && !probe_ack) begin
                if (gap_arm)
                    check(gap_cnt == SC, "R9", "settle gap", gap_cnt, SC);
                gap_arm = 0;
                if (exp_tap_q.size() == 0) begin
                    check(0, "R5", "unexpected probe tap", tap_sel, 0);
                end else begin
                    int et;
                    et = exp_tap_q.pop_front();
                    check(tap_sel == TW'(et), "R5", "probe tap", tap_sel, et);
                end
                for (int d = 0; d < ack_delay; d++) begin
                    @(negedge clk);
                    check(probe_req == 1'b1, "R8", "request held", probe_req, 1);
                end
                probe_ack = 1'b1;
                probe_cmd_ok = pass_pat[probes_seen % VW];
                probe_cmp_word = cmp_pat[probes_seen % VW] ? '0 : 8'h5A;
                probes_seen++;
                @(negedge clk);
                probe_ack = 1'b0;
                probe_cmd_ok = 1'b0;
                probe_cmp_word = '1;
                gap_cnt = 1;
                gap_arm = 1;
            end else if (!probe_req) begin
                if (!busy) gap_arm = 0;
                if (busy && gap_arm) gap_cnt++;
                if (spurious && busy && gap_arm && gap_cnt == 2) begin
                    probe_ack = 1'b1;
                    probe_cmd_ok = ~pass_pat[probes_seen % VW];
                    probe_cmp_word = '0;
                    @(negedge clk);
                    probe_ack = 1'b0;
                    probe_cmd_ok = 1'b0;
                    probe_cmp_word = '1;
                    if (!probe_req) gap_cnt++;
                end
            end
        end
    end

    // Monitor: on each finish pulse, compare against the scoreboard head.
    initial begin : finish_monitor
        forever begin
            @(negedge clk);
            if (done) begin
                check(!done_prev, "R11", "done width", done_prev, 0);
                if (exp_res_q.size() == 0) begin
                    check(0, "R11", "unexpected done", status, 0);
                end else begin
                    res_t r;
                    r = exp_res_q.pop_front();
                    check(status == r.st, st_tag(r.st), "status", status, r.st);
                    check(pass_vec == r.pv, "R6", "pass vector", pass_vec, r.pv);
                    check(cmp_vec == r.cv, "R7", "compare vector", cmp_vec, r.cv);
                    check(probes_seen == r.probes, "R5", "probe count", probes_seen, r.probes);
                    check(exp_tap_q.size() == 0, "R5", "taps left", exp_tap_q.size(), 0);
                end
            end
            done_prev = done;
        end
    end

    // Driver: compute the expected outcome, push it, and issue the request.
    task automatic run(input logic [1:0] m, input int n, input logic [VW-1:0] pp,
                       input logic [VW-1:0] cp, input int dly, input bit spur,
                       input bit busy_start);
        res_t r;
        logic [VW-1:0] mask;
        int twon;
        twon = 2 * n;
        mask = (twon >= VW) ? '1 : ((VW'(1) << twon) - 1'b1);
        r.pv = '0;
        r.cv = '0;
        r.probes = 0;
        if (!m[1]) r.st = 2'b01;
        else if (n == 0) r.st = 2'b10;
        else if (twon >= VW) r.st = 2'b11;
        else begin
            r.st = 2'b00;
            r.pv = pp & mask;
            r.cv = cp & mask;
            r.probes = twon;
            for (int i = 0; i < twon; i++) exp_tap_q.push_back(i % n);
        end
        exp_res_q.push_back(r);
        pass_pat = pp;
        cmp_pat = cp;
        ack_delay = dly;
        spurious = spur;
        probes_seen = 0;
        @(negedge clk);
        bus_mode = m;
        tap_count = TW'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (r.st != 2'b00) begin
            check(done == 1'b1, st_tag(r.st), "immediate done", done, 1);
            check(probe_req == 1'b0, st_tag(r.st), "no probe", probe_req, 0);
        end
        if (busy_start) begin
            repeat (3) @(negedge clk);
            tap_count = TW'(n + 2);
            bus_mode = 2'b00;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b1, "R10", "busy after ignored start", busy, 1);
        end
        while (!done) @(negedge clk);
        repeat (2) @(negedge clk);
        check(busy == 1'b0, "R11", "idle after done", busy, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1", "reset busy", busy, 0);
        check(done == 1'b0, "R1", "reset done", done, 0);
        check(probe_req == 1'b0, "R1", "reset request", probe_req, 0);
        check(status == 2'b00, "R1", "reset status", status, 0);
        check(pass_vec == '0 && cmp_vec == '0, "R1", "reset vectors", pass_vec | cmp_vec, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(2'b00, 5, '1, '1, 0, 0, 0);                  // R2
        run(2'b01, 5, '1, '1, 0, 0, 0);                  // R2
        run(2'b10, 0, '1, '1, 0, 0, 0);                  // R3
        run(2'b11, 8, '1, '1, 0, 0, 0);                  // R4 at the limit
        run(2'b10, 9, '1, '1, 0, 0, 0);                  // R4
        run(2'b11, 200, '1, '1, 0, 0, 0);                // R4 large count
        run(2'b10, 7, 16'h3F7E, 16'h1C3B, 0, 0, 0);      // R5 R6 R7 largest sweep
        run(2'b11, 8, '1, '1, 0, 0, 0);                  // R6 R7 stale results cleared
        run(2'b11, 3, 16'hFFFF, 16'b101101, 2, 0, 0);    // R8 delayed acks
        run(2'b10, 1, 16'b10, 16'b01, 0, 0, 0);          // R5 single tap
        run(2'b11, 4, 16'h00B7, 16'h00E5, 1, 1, 1);      // R8 stray acks, R10
        run(2'b01, 3, '1, '1, 0, 0, 0);                  // R2 clears previous results

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule